// File: doc/BRIEF.md
# Width-Aware Iterative Narrow Compute Array

This block evaluates a small two-row dataflow pattern over four 32-bit operands using only 8-bit functional units. Row one holds two units: the left one combines operands A and B, the right one combines C and D. Row two holds a single unit that combines the two row-one results. Each unit is programmed by a 3-bit field of a 9-bit configuration word to add, subtract, AND, OR or XOR.

The operands are handled one byte slice per clock, starting at the least significant byte. Carries from the arithmetic units are held from one slice to the next. Each slice result goes into the matching byte lane of two 32-bit result registers. A width check runs after every slice. Once the remaining upper bits of all four operands are zero and no carry is pending, the operation ends early. Narrow data therefore finishes in fewer cycles than full-width data.

A caller raises `start` for one cycle while the block is idle. It then waits for the one-cycle `done` pulse and reads both results. The results stay in place until the next accepted start.

Top module: `nca_array`

## Requirements
- R1: After a synchronous reset, `done` and `busy` are 0 and both results read 0.
- R2: Configuration fields select the units: bits [2:0] set the left row-one unit, bits [5:3] the right row-one unit and bits [8:6] the row-two unit. The codes are 0 ADD, 1 SUB, 2 AND, 3 OR, 4 XOR. `res_side` is the left unit applied to (A, B). `res_main` is the row-two unit applied to (left result, right result), where the right result is the right unit applied to (C, D). Both are exact modulo 2^32.
- R3: With the units set to ADD, OR and ADD, the operands 0x1D, 0x0C, 0x20 and 0x08 give `res_main` = 0x51 and `res_side` = 0x29, and `done` rises one cycle after the start edge.
- R4: When no unit is set to SUB, the iteration count n is the number of bytes up to the highest nonzero byte of the largest of A, B, C, D, the left result, the right result and the row-two result, with a minimum of 1. `done` is high in the n-th cycle after the edge that accepts `start`.
- R5: A carry out of one byte slice is added into the next slice. For example, 0xFF + 0x01 yields 0x100 after 2 iterations.
- R6: If any unit is set to SUB, the operation always takes 4 iterations and the results are exact modulo 2^32.
- R7: `done` is high for exactly one cycle. `busy` is high from the accepting edge until the final iteration and is low while `done` is high.
- R8: `start` is ignored while `busy` is high. The operation in flight completes with its own operands and configuration.
- R9: Codes 5, 6 and 7 make a unit behave as ADD.
- R10: Both results hold their values from `done` until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an operation when idle |
| opnd_a | input | 32 | Operand A (left row-one unit, first input) |
| opnd_b | input | 32 | Operand B (left row-one unit, second input) |
| opnd_c | input | 32 | Operand C (right row-one unit, first input) |
| opnd_d | input | 32 | Operand D (right row-one unit, second input) |
| cfg | input | 9 | Three 3-bit unit selects |
| res_main | output | 32 | Row-two unit result |
| res_side | output | 32 | Left row-one unit result |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Directed cases come first. The worked byte example checks single-slice routing. A 0xFF + 0x01 case shows whether carries cross slices. Small subtractions, which would end early without the forced full run, catch a block that stops too soon under SUB. Random operations follow. They use operands masked to 1 to 4 bytes and random unit codes, including the unused codes. Some of these patterns overflow into a higher byte only through the row-two adder. The measured latency then tells correct width and carry detection apart from detection that looks only at the operands. A start pulse sent in mid-operation, with different data, shows whether the in-flight operation is protected.

// File: rtl/nca_pkg.sv
package nca_pkg;
  localparam int FU_SEL_W = 3;
  localparam int FU_COUNT = 3;

  typedef enum logic [FU_SEL_W-1:0] {
    FU_ADD = 3'd0,
    FU_SUB = 3'd1,
    FU_AND = 3'd2,
    FU_OR  = 3'd3,
    FU_XOR = 3'd4
  } fu_op_e;

  function automatic logic sel_is_sub(logic [FU_SEL_W-1:0] sel);
    return sel == FU_SUB;
  endfunction
endpackage

// File: rtl/nca_fu.sv
module nca_fu
  import nca_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [FU_SEL_W-1:0] sel,
  input  logic [W-1:0]        in_x,
  input  logic [W-1:0]        in_y,
  input  logic                first_slice,
  input  logic                carry_held,
  output logic [W-1:0]        slice_out,
  output logic                carry_out
);
  localparam int W1 = W + 1;

  function automatic logic [W:0] fu_eval(logic [FU_SEL_W-1:0] s,
                                         logic [W-1:0] x, logic [W-1:0] y,
                                         logic ci);
    case (s)
      FU_SUB:  return {1'b0, x} + {1'b0, ~y} + W1'(ci);
      FU_AND:  return {1'b0, x & y};
      FU_OR:   return {1'b0, x | y};
      FU_XOR:  return {1'b0, x ^ y};
      default: return {1'b0, x} + {1'b0, y} + W1'(ci);
    endcase
  endfunction

  logic       carry_in;
  logic [W:0] full;

  always_comb begin
    carry_in  = first_slice ? sel_is_sub(sel) : carry_held;
    full      = fu_eval(sel, in_x, in_y, carry_in);
    slice_out = full[W-1:0];
    carry_out = full[W];
  end
endmodule

// File: rtl/nca_width_check.sv
module nca_width_check
  import nca_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int SLICE_W = 8
) (
  input  logic [DATA_W-1:0]           opnd_now [4],
  input  logic [FU_COUNT-1:0]         couts,
  input  logic [FU_COUNT*FU_SEL_W-1:0] cfg_now,
  output logic                        any_sub,
  output logic                        iterate
);
  logic upper_nz;

  always_comb begin
    upper_nz = 1'b0;
    for (int i = 0; i < 4; i++)
      upper_nz = upper_nz | (|opnd_now[i][DATA_W-1:SLICE_W]);
    any_sub = 1'b0;
    for (int u = 0; u < FU_COUNT; u++)
      any_sub = any_sub | sel_is_sub(cfg_now[u*FU_SEL_W +: FU_SEL_W]);
    iterate = upper_nz | (|couts) | any_sub;
  end
endmodule

// File: rtl/nca_iter_ctrl.sv
module nca_iter_ctrl #(
  parameter int NSLICE = 4,
  parameter int IDX_W  = (NSLICE > 1) ? $clog2(NSLICE) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             iterate,
  input  logic             any_sub,
  output logic             accept,
  output logic             step,
  output logic             last,
  output logic             first_slice,
  output logic [IDX_W-1:0] idx,
  output logic             busy,
  output logic             done
);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NSLICE - 1);

  logic             busy_q, done_q;
  logic [IDX_W-1:0] idx_q;

  assign accept      = start & ~busy_q;
  assign step        = busy_q;
  assign last        = busy_q & ((idx_q == IDX_LAST) | ~iterate);
  assign first_slice = (idx_q == '0);
  assign idx         = idx_q;
  assign busy        = busy_q;
  assign done        = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      done_q <= last;
      if (accept) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
      end else if (last) begin
        busy_q <= 1'b0;
        idx_q  <= '0;
      end else if (step) begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_busy_low_at_done_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  p_sub_full_run_r6: assert property (@(posedge clk) disable iff (rst)
    (busy && any_sub && idx != IDX_LAST) |-> !last);
endmodule

// File: rtl/nca_array.sv
module nca_array
  import nca_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int SLICE_W = 8,
  parameter int CFG_W   = FU_COUNT * FU_SEL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [DATA_W-1:0] opnd_c,
  input  logic [DATA_W-1:0] opnd_d,
  input  logic [CFG_W-1:0]  cfg,
  output logic [DATA_W-1:0] res_main,
  output logic [DATA_W-1:0] res_side,
  output logic              busy,
  output logic              done
);
  localparam int NSLICE = DATA_W / SLICE_W;
  localparam int IDX_W  = (NSLICE > 1) ? $clog2(NSLICE) : 1;

  logic [DATA_W-1:0]   opnd_q [4];
  logic [CFG_W-1:0]    cfg_q;
  logic [FU_COUNT-1:0] carry_q;
  logic [DATA_W-1:0]   res_main_q, res_side_q;

  logic [SLICE_W-1:0]  fu_x [FU_COUNT];
  logic [SLICE_W-1:0]  fu_y [FU_COUNT];
  logic [SLICE_W-1:0]  fu_out [FU_COUNT];
  logic [FU_COUNT-1:0] fu_cout;

  logic             accept, step, last, first_slice, iterate, any_sub;
  logic [IDX_W-1:0] idx;

  always_comb begin
    fu_x[0] = opnd_q[0][SLICE_W-1:0];
    fu_y[0] = opnd_q[1][SLICE_W-1:0];
    fu_x[1] = opnd_q[2][SLICE_W-1:0];
    fu_y[1] = opnd_q[3][SLICE_W-1:0];
    fu_x[2] = fu_out[0];
    fu_y[2] = fu_out[1];
  end

  for (genvar u = 0; u < FU_COUNT; u++) begin : g_fu
    nca_fu #(.W(SLICE_W)) u_fu (
      .sel        (cfg_q[u*FU_SEL_W +: FU_SEL_W]),
      .in_x       (fu_x[u]),
      .in_y       (fu_y[u]),
      .first_slice(first_slice),
      .carry_held (carry_q[u]),
      .slice_out  (fu_out[u]),
      .carry_out  (fu_cout[u])
    );
  end

  logic [DATA_W-1:0] opnd_next [4];
  always_comb
    for (int i = 0; i < 4; i++) opnd_next[i] = opnd_q[i] >> SLICE_W;

  nca_width_check #(.DATA_W(DATA_W), .SLICE_W(SLICE_W)) u_wchk (
    .opnd_now(opnd_q),
    .couts   (fu_cout),
    .cfg_now (cfg_q),
    .any_sub (any_sub),
    .iterate (iterate)
  );

  nca_iter_ctrl #(.NSLICE(NSLICE)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .iterate    (iterate),
    .any_sub    (any_sub),
    .accept     (accept),
    .step       (step),
    .last       (last),
    .first_slice(first_slice),
    .idx        (idx),
    .busy       (busy),
    .done       (done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 4; i++) opnd_q[i] <= '0;
      cfg_q      <= '0;
      carry_q    <= '0;
      res_main_q <= '0;
      res_side_q <= '0;
    end else if (accept) begin
      opnd_q[0]  <= opnd_a;
      opnd_q[1]  <= opnd_b;
      opnd_q[2]  <= opnd_c;
      opnd_q[3]  <= opnd_d;
      cfg_q      <= cfg;
      carry_q    <= '0;
      res_main_q <= '0;
      res_side_q <= '0;
    end else if (step) begin
      for (int i = 0; i < 4; i++) opnd_q[i] <= opnd_next[i];
      carry_q <= fu_cout;
      res_main_q[idx*SLICE_W +: SLICE_W] <= fu_out[2];
      res_side_q[idx*SLICE_W +: SLICE_W] <= fu_out[0];
    end
  end

  assign res_main = res_main_q;
  assign res_side = res_side_q;

  p_start_ignored_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && !last) |=> $stable(cfg_q));
  p_results_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> ($stable(res_main_q) && $stable(res_side_q)));
  p_accept_clears_r2: assert property (@(posedge clk) disable iff (rst)
    accept |=> (busy && res_main_q == '0 && res_side_q == '0));
endmodule

// File: tb/nca_array_test.sv
module nca_array_test;
  localparam int CLK_NS = 20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] a = '0, b = '0, c = '0, d = '0;
  logic [8:0]  cfg = '0;
  logic [31:0] res_main, res_side;
  logic        busy, done;

  int total = 0;
  int bad = 0;

  always #(CLK_NS/2) clk = ~clk;

  nca_array uut (
    .clk(clk), .rst(rst), .start(start),
    .opnd_a(a), .opnd_b(b), .opnd_c(c), .opnd_d(d), .cfg(cfg),
    .res_main(res_main), .res_side(res_side), .busy(busy), .done(done)
  );

  function automatic logic [31:0] ref_op(logic [2:0] s, logic [31:0] x, logic [31:0] y);
    case (s)
      3'd1: return x - y;
      3'd2: return x & y;
      3'd3: return x | y;
      3'd4: return x ^ y;
      default: return x + y;
    endcase
  endfunction

  function automatic int byte_len(logic [31:0] v);
    int n = 1;
    for (int k = 1; k < 4; k++) if ((v >> (8*k)) != 0) n = k + 1;
    return n;
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=0x%08h expected=0x%08h", req, what, act, exp);
    end
  endtask

  task automatic run_op(string req, logic [31:0] xa, logic [31:0] xb,
                        logic [31:0] xc, logic [31:0] xd, logic [8:0] xcfg);
    logic [31:0] l, r, y;
    int n, cnt;
    logic busy_ok;
    l = ref_op(xcfg[2:0], xa, xb);
    r = ref_op(xcfg[5:3], xc, xd);
    y = ref_op(xcfg[8:6], l, r);
    if (xcfg[2:0] == 3'd1 || xcfg[5:3] == 3'd1 || xcfg[8:6] == 3'd1) n = 4;
    else begin
      n = 1;
      foreach (xa[i]) begin end
      if (byte_len(xa) > n) n = byte_len(xa);
      if (byte_len(xb) > n) n = byte_len(xb);
      if (byte_len(xc) > n) n = byte_len(xc);
      if (byte_len(xd) > n) n = byte_len(xd);
      if (byte_len(l) > n) n = byte_len(l);
      if (byte_len(r) > n) n = byte_len(r);
      if (byte_len(y) > n) n = byte_len(y);
    end
    @(negedge clk);
    a = xa; b = xb; c = xc; d = xd; cfg = xcfg; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    cnt = 0;
    busy_ok = 1'b1;
    while (cnt < 10) begin
      if (!busy) busy_ok = 1'b0;
      @(posedge clk);
      cnt++;
      @(negedge clk);
      if (done) break;
    end
    check("R7", "busy during run", {31'd0, busy_ok}, 32'd1);
    check({req, "/R4"}, "latency", cnt, n);
    check("R7", "busy at done", {31'd0, busy}, 32'd0);
    check({req, "/R2"}, "res_main", res_main, y);
    check({req, "/R2"}, "res_side", res_side, l);
    a = ~xa; b = ~xb; cfg = ~xcfg;
    @(negedge clk);
    check("R7", "done one cycle", {31'd0, done}, 32'd0);
    check("R10", "res_main held", res_main, y);
    check("R10", "res_side held", res_side, l);
  endtask

  initial begin
    #(CLK_NS * 200000);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "done after reset", {31'd0, done}, 32'd0);
    check("R1", "busy after reset", {31'd0, busy}, 32'd0);
    check("R1", "res_main after reset", res_main, 32'd0);
    check("R1", "res_side after reset", res_side, 32'd0);

    // R3 worked example: left ADD, right OR, row two ADD
    run_op("R3", 32'h1D, 32'h0C, 32'h20, 32'h08, {3'd0, 3'd3, 3'd0});
    // R5 carry across slices
    run_op("R5", 32'hFF, 32'h01, 32'h0, 32'h0, {3'd0, 3'd0, 3'd0});
    run_op("R5", 32'h00FF_FFFF, 32'h1, 32'h0, 32'h0, {3'd0, 3'd2, 3'd0});
    run_op("R5", 32'hFFFF_FFFF, 32'h1, 32'h0, 32'h0, {3'd0, 3'd0, 3'd0});
    // row-two overflow only
    run_op("R4", 32'h80, 32'h0, 32'h80, 32'h0, {3'd0, 3'd0, 3'd0});
    // R6 subtraction forces a full run
    run_op("R6", 32'd5, 32'd7, 32'd0, 32'd0, {3'd0, 3'd0, 3'd1});
    run_op("R6", 32'd9, 32'd3, 32'd1, 32'd1, {3'd1, 3'd0, 3'd0});
    // R9 unused codes act as ADD
    run_op("R9", 32'hF0, 32'h20, 32'h7, 32'h9, {3'd7, 3'd5, 3'd6});

    // R8 start during busy is ignored
    begin
      int cnt;
      @(negedge clk);
      a = 32'd100; b = 32'd1; c = 32'd3; d = 32'd2; cfg = {3'd0, 3'd0, 3'd1}; start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      a = 32'hDEAD_BEEF; b = 32'h1234_5678; cfg = '0;
      @(negedge clk);
      start = 1'b0;
      cnt = 1;
      while (!done && cnt < 10) begin @(negedge clk); cnt++; end
      check("R8", "latency unchanged", cnt, 32'd4);
      check("R8", "res_side of first op", res_side, 32'd99);
      check("R8", "res_main of first op", res_main, 32'd104);
    end

    for (int t = 0; t < 300; t++) begin
      logic [31:0] v [4];
      logic [8:0] rc;
      for (int i = 0; i < 4; i++) begin
        int nb = ($urandom % 4) + 1;
        v[i] = $urandom;
        if (nb < 4) v[i] = v[i] & ((32'd1 << (8*nb)) - 1);
      end
      for (int u = 0; u < 3; u++) begin
        int pick = $urandom % 10;
        rc[u*3 +: 3] = (pick < 8) ? 3'(pick % 5) : 3'(5 + pick % 3);
      end
      if (($urandom % 3) != 0)
        for (int u = 0; u < 3; u++) if (rc[u*3 +: 3] == 3'd1) rc[u*3 +: 3] = 3'd0;
      run_op("R2", v[0], v[1], v[2], v[3], rc);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule